// File: doc/BRIEF.md
# Biphase Mark Line Encoder

This block serialises a stream of data bits onto one wire using biphase mark coding. Time is divided into cells of `CELL_TICKS` clock cycles. The wire changes level at the start of every cell. For a 1 bit, it changes level a second time `MARK_TICKS` cycles into the cell. For a 0 bit, it holds its level for the whole cell. A receiver can therefore recover both the bit timing and the data from the edges alone. The split point does not have to be half the cell. Any `MARK_TICKS` from 1 to `CELL_TICKS-1` is accepted, for example 16 of 32, 8 of 16, 5 of 18, 4 of 11 or 7 of 14.

A producer offers bits with a valid/ready handshake. The encoder raises `bit_ready` for one cycle per cell. That is the cycle before the cell begins, and the bit present in that cycle is stored for the whole cell. If no bit is offered in that cycle, the encoder sends a 0 cell and flags an underrun for that cell.

Top module: `bmc_line_encoder`

## Requirements
- R1: While `rst` is high and after it falls, `line_out` is 0, `underrun` is 0 and `bit_ready` is 0. The first `bit_ready` appears after exactly `CELL_TICKS-1` rising edges with reset low, and `line_out` stays 0 until the cell that follows it.
- R2: `bit_ready` is high for exactly one cycle in every `CELL_TICKS` cycles, and never for two consecutive cycles.
- R3: On the rising edge that ends each `bit_ready` cycle, a cell starts and `line_out` inverts. This happens whether the bit is 0 or 1 and whether or not a bit was offered.
- R4: When the stored bit is 1, `line_out` inverts a second time exactly `MARK_TICKS` cycles after the cell-start inversion.
- R5: When the stored bit is 0, `line_out` keeps one level for all `CELL_TICKS` cycles of the cell.
- R6: The bit is sampled only in the `bit_ready` cycle (transfer when `bit_valid` and `bit_ready` are both 1). Changes to `bit_data` or `bit_valid` during a cell do not alter that cell's waveform.
- R7: If `bit_valid` is 0 in the `bit_ready` cycle, the cell is sent as a 0 and `underrun` is 1 for that cell. `underrun` is 0 for a cell whose bit was transferred. `underrun` changes only at cell starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock; one cycle is one tick |
| rst | input | 1 | Synchronous reset, active high |
| bit_data | input | 1 | Data bit offered by the producer |
| bit_valid | input | 1 | Producer has a bit on `bit_data` |
| bit_ready | output | 1 | Encoder takes a bit in this cycle (once per cell) |
| line_out | output | 1 | Biphase mark coded line |
| underrun | output | 1 | Current cell was sent without a bit offered |

## Verification
The assertions assume that `bit_valid` and `bit_data` are synchronous to `clk` and settled at each rising edge. They also assume that the checker's own tick count, restarted by every `bit_ready`, tracks cell position. This holds only if reset is applied synchronously for at least one edge. The stimulus changes inputs only on falling edges and holds reset across several edges. It also deliberately flips `bit_data` and `bit_valid` inside every cell, so the assertions and the bench both see mid-cell activity that must be ignored.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  // Information held for one cell once its bit has been taken.
  typedef struct packed {
    logic bit_val;  // level of the coded bit (0 when starved)
    logic starved;  // no bit was offered when the cell began
  } bmc_cell_t;

endpackage

// File: rtl/bmc_tick_counter.sv
module bmc_tick_counter #(
  parameter int CELL_TICKS = 32,
  parameter int MARK_TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  output logic cell_wrap,
  output logic mark_hit,
  output logic req_q
);
  localparam int TW = (CELL_TICKS > 2) ? $clog2(CELL_TICKS) : 1;
  localparam logic [TW-1:0] LAST     = TW'(CELL_TICKS - 1);
  localparam logic [TW-1:0] PRE_LAST = TW'(CELL_TICKS - 2);
  localparam logic [TW-1:0] MARK_END = TW'(MARK_TICKS - 1);

  if (MARK_TICKS < 1 || MARK_TICKS >= CELL_TICKS) begin : g_bad_split
    $error("bmc_tick_counter: MARK_TICKS must lie in 1..CELL_TICKS-1");
  end

  logic [TW-1:0] tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
      req_q  <= 1'b0;
    end else begin
      tick_q <= (tick_q == LAST) ? '0 : tick_q + 1'b1;
      req_q  <= (tick_q == PRE_LAST);
    end
  end

  assign cell_wrap = (tick_q == LAST);
  assign mark_hit  = (tick_q == MARK_END);
endmodule

// File: rtl/bmc_bit_latch.sv
module bmc_bit_latch
  import bmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      take,
  input  logic      bit_valid,
  input  logic      bit_data,
  output bmc_cell_t cell_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cell_q <= '0;
    end else if (take) begin
      cell_q.bit_val <= bit_valid & bit_data;
      cell_q.starved <= ~bit_valid;
    end
  end
endmodule

// File: rtl/bmc_line_driver.sv
module bmc_line_driver (
  input  logic clk,
  input  logic rst,
  input  logic cell_wrap,
  input  logic mark_hit,
  input  logic bit_one,
  output logic line_q
);
  logic flip;
  assign flip = cell_wrap | (mark_hit & bit_one);

  always_ff @(posedge clk) begin
    if (rst)       line_q <= 1'b0;
    else if (flip) line_q <= ~line_q;
  end
endmodule

// File: rtl/bmc_line_encoder.sv
module bmc_line_encoder
  import bmc_pkg::*;
#(
  parameter int CELL_TICKS = 32,
  parameter int MARK_TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_data,
  input  logic bit_valid,
  output logic bit_ready,
  output logic line_out,
  output logic underrun
);
  logic      cell_wrap;
  logic      mark_hit;
  logic      line_q;
  bmc_cell_t cell_q;

  bmc_tick_counter #(
    .CELL_TICKS(CELL_TICKS),
    .MARK_TICKS(MARK_TICKS)
  ) u_ticks (
    .clk      (clk),
    .rst      (rst),
    .cell_wrap(cell_wrap),
    .mark_hit (mark_hit),
    .req_q    (bit_ready)
  );

  bmc_bit_latch u_latch (
    .clk      (clk),
    .rst      (rst),
    .take     (cell_wrap),
    .bit_valid(bit_valid),
    .bit_data (bit_data),
    .cell_q   (cell_q)
  );

  bmc_line_driver u_line (
    .clk      (clk),
    .rst      (rst),
    .cell_wrap(cell_wrap),
    .mark_hit (mark_hit),
    .bit_one  (cell_q.bit_val),
    .line_q   (line_q)
  );

  assign line_out = line_q;
  assign underrun = cell_q.starved;
endmodule

// File: rtl/bmc_line_encoder_chk.sv
module bmc_line_encoder_chk #(
  parameter int CELL_TICKS = 32,
  parameter int MARK_TICKS = 16
) (
  input logic clk,
  input logic rst,
  input logic bit_data,
  input logic bit_valid,
  input logic bit_ready,
  input logic line_out,
  input logic underrun
);
  localparam int PW = $clog2(CELL_TICKS + 1);

  logic [PW-1:0] pos_q;
  logic          sent_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      sent_q <= 1'b0;
    end else if (bit_ready) begin
      pos_q  <= '0;
      sent_q <= bit_valid & bit_data;
    end else begin
      pos_q  <= pos_q + 1'b1;
    end
  end

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!line_out && !underrun && !bit_ready));

  // R2
  a_r2_single_request: assert property (@(posedge clk) disable iff (rst)
    bit_ready |=> !bit_ready);

  // R3
  a_r3_start_toggle: assert property (@(posedge clk) disable iff (rst)
    bit_ready |=> (line_out != $past(line_out)));

  // R4
  a_r4_mark_toggle: assert property (@(posedge clk) disable iff (rst)
    (pos_q == PW'(MARK_TICKS - 1) && sent_q && !bit_ready) |=> (line_out != $past(line_out)));

  // R5
  a_r5_zero_flat: assert property (@(posedge clk) disable iff (rst)
    (!bit_ready && !sent_q) |=> $stable(line_out));

  // R7
  a_r7_underrun_flag: assert property (@(posedge clk) disable iff (rst)
    bit_ready |=> (underrun == !$past(bit_valid)));

  // R7
  a_r7_underrun_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_ready |=> $stable(underrun));
endmodule

bind bmc_line_encoder bmc_line_encoder_chk #(
  .CELL_TICKS(CELL_TICKS),
  .MARK_TICKS(MARK_TICKS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bit_data (bit_data),
  .bit_valid(bit_valid),
  .bit_ready(bit_ready),
  .line_out (line_out),
  .underrun (underrun)
);

// File: tb/bmc_line_encoder_test.sv
`timescale 1ns/1ps
module bmc_line_encoder_test;
  localparam int CELL = 32;
  localparam int MARK = 16;
  localparam int NVEC = 12;
  // each entry: {bit_valid, bit_data}
  localparam logic [1:0] VEC [0:NVEC-1] = '{
    2'b11, 2'b10, 2'b11, 2'b11, 2'b00, 2'b10,
    2'b01, 2'b11, 2'b10, 2'b00, 2'b11, 2'b10
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_data = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_ready;
  logic line_out;
  logic underrun;

  int checks = 0;
  int fails = 0;
  logic exp_line = 1'b0;

  always #10 clk = ~clk;

  bmc_line_encoder #(.CELL_TICKS(CELL), .MARK_TICKS(MARK)) uut (
    .clk(clk), .rst(rst), .bit_data(bit_data), .bit_valid(bit_valid),
    .bit_ready(bit_ready), .line_out(line_out), .underrun(underrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // After reset release: count edges to the first request, line must stay 0.
  task automatic first_request();
    int n = 0;
    bit quiet = 1'b1;
    while (!bit_ready && n < 4 * CELL) begin
      @(negedge clk);
      n++;
      if (line_out !== 1'b0) quiet = 1'b0;
      bit_data = ~bit_data;  // ignored: no request yet
    end
    check(n == CELL - 1, "R1 first request delay", n, CELL - 1);
    check(quiet, "R1 line idle before first cell", quiet, 1);
    exp_line = 1'b0;
  endtask

  // Precondition: at a falling edge with bit_ready high.
  task automatic do_cell(input logic v, input logic d);
    bit_valid = v;
    bit_data  = d;
    @(negedge clk);
    exp_line = ~exp_line;
    check(line_out == exp_line, "R3 start toggle", line_out, exp_line);
    check(underrun == !v, "R7 underrun flag", underrun, !v);
    check(bit_ready == 1'b0, "R2 request dropped", bit_ready, 0);
    bit_data  = ~d;   // R6: mid-cell changes
    bit_valid = ~v;
    for (int p = 1; p < CELL; p++) begin
      @(negedge clk);
      if (p == 3) bit_data = d;
      if (p == MARK) begin
        if (v && d) begin
          exp_line = ~exp_line;
          check(line_out == exp_line, "R4 mark toggle", line_out, exp_line);
        end else begin
          check(line_out == exp_line, "R5 zero cell flat", line_out, exp_line);
        end
      end
      if (p == MARK - 1)
        check(line_out == exp_line, "R6 first half level", line_out, exp_line);
      if (p == CELL - 2)
        check(bit_ready == 1'b0, "R2 no early request", bit_ready, 0);
      if (p == CELL - 1) begin
        check(line_out == exp_line, "R5 cell end level", line_out, exp_line);
        check(bit_ready == 1'b1, "R2 request per cell", bit_ready, 1);
        check(underrun == !v, "R7 underrun held", underrun, !v);
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1 completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(line_out == 1'b0, "R1 reset line", line_out, 0);
    check(underrun == 1'b0, "R1 reset underrun", underrun, 0);
    check(bit_ready == 1'b0, "R1 reset ready", bit_ready, 0);
    rst = 1'b0;
    first_request();
    for (int i = 0; i < NVEC; i++) do_cell(VEC[i][1], VEC[i][0]);

    // Reset in the middle of a 1 cell, after both toggles.
    bit_valid = 1'b1;
    bit_data  = 1'b1;
    repeat (MARK + 2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(line_out == 1'b0, "R1 mid-cell reset line", line_out, 0);
    check(underrun == 1'b0, "R1 mid-cell reset underrun", underrun, 0);
    check(bit_ready == 1'b0, "R1 mid-cell reset ready", bit_ready, 0);
    @(negedge clk);
    rst = 1'b0;
    first_request();
    do_cell(1'b0, 1'b0);
    do_cell(1'b1, 1'b1);
    report();
  end
endmodule